// File: doc/BRIEF.md
# Packed SIMD Integer Media Unit

This block is a single-stage execution unit for 64-bit packed integer work. Each operation takes two 64-bit operands, an 8-bit immediate and a 3-bit opcode. All eight operations are computed in parallel from the same operands. The opcode picks one of them, and the chosen value is registered on the clock edge that samples an input valid strobe.

Some operations work on each lane independently: unsigned byte max/min, signed word max/min and the unsigned word multiply that keeps the high half. Others combine lanes. One sums the absolute byte differences into a single word. One gathers the top bit of every byte into a scalar mask. One rearranges the words of the first operand under control of the immediate.

Top module: `simd_media_unit`

## Requirements
- R1: Synchronous reset clears `out_valid` to 0 and `result` to all zeros; this also applies to a reset asserted in the middle of operation.
- R2: When `in_valid` is high at a rising edge, `out_valid` is 1 after that edge and `result` holds the selected value; when `in_valid` is low, `out_valid` is 0 after the edge and `result` keeps its previous value.
- R3: Opcode 0: each 8-bit lane of `result` is the unsigned larger of the matching lanes of `src_a` and `src_b`.
- R4: Opcode 1: each 8-bit lane of `result` is the unsigned smaller of the matching lanes.
- R5: Opcode 2 / opcode 3: each 16-bit lane is the larger / smaller of the matching lanes, both read as two's-complement signed values.
- R6: Opcode 4: each 16-bit lane is bits [31:16] of the unsigned 32-bit product of the matching 16-bit lanes.
- R7: Opcode 5: `result[15:0]` is the sum of |a_i − b_i| over the eight unsigned byte lanes; `result[63:16]` is zero.
- R8: Opcode 6: `result[i]` equals bit 7 of byte lane i of `src_a` for i = 0..7; `result[63:8]` is zero; `src_b` has no effect.
- R9: Opcode 7: destination word k (bits [16k+15:16k]) is the word of `src_a` whose index is `imm[2k+1:2k]`; `src_b` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are sampled at this edge |
| op | input | 3 | Operation select (0..7, see R3–R9) |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| imm | input | 8 | Word shuffle control, two bits per destination word |
| out_valid | output | 1 | Result was updated at the last edge |
| result | output | 64 | Registered result |

## Verification
The unsigned byte max and min are swept over every one of the 65,536 byte pairs, eight pairs per operand, so each boundary between equal, larger and smaller values is covered. The signed word operations and the multiply use a grid of corner values (0, 1, 0x7FFF, 0x8000, 0xFFFF and neighbours), which separates a signed compare from an unsigned one and exposes a wrong product half, followed by pseudo-random words. The sum of absolute differences is tried with identical operands, with the all-0xFF versus all-zero extreme of 2040, and with random bytes. The mask is tried over all 256 top-bit patterns, each with random lower bits and a random second operand. The shuffle is tried over all 256 immediates, with a random second operand to show it is ignored. Idle cycles with changing inputs show that the result holds.

// File: rtl/simd_media_pkg.sv
package simd_media_pkg;

    typedef enum logic [2:0] {
        OP_UMAX8   = 3'd0,
        OP_UMIN8   = 3'd1,
        OP_SMAX16  = 3'd2,
        OP_SMIN16  = 3'd3,
        OP_MULHI16 = 3'd4,
        OP_SAD8    = 3'd5,
        OP_MSBMASK = 3'd6,
        OP_WSHUF   = 3'd7
    } smu_op_e;

    localparam int SMU_DATA_W = 64;

endpackage

// File: rtl/smu_byte_unit.sv
module smu_byte_unit #(
    parameter int NB    = 8,
    parameter int SUM_W = 11
) (
    input  logic [NB*8-1:0] a,
    input  logic [NB*8-1:0] b,
    output logic [NB*8-1:0] umax,
    output logic [NB*8-1:0] umin,
    output logic [SUM_W-1:0] sad,
    output logic [NB-1:0]   msb
);

    logic [7:0] diff [NB];

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [7:0] x;
        logic [7:0] y;
        logic       a_gt;
        assign x    = a[8*i +: 8];
        assign y    = b[8*i +: 8];
        assign a_gt = x > y;
        assign umax[8*i +: 8] = a_gt ? x : y;
        assign umin[8*i +: 8] = a_gt ? y : x;
        assign diff[i]        = a_gt ? (x - y) : (y - x);
        assign msb[i]         = x[7];
    end

    always_comb begin
        sad = '0;
        for (int i = 0; i < NB; i++) begin
            sad = sad + SUM_W'(diff[i]);
        end
    end

endmodule

// File: rtl/smu_word_unit.sv
module smu_word_unit #(
    parameter int NW    = 4,
    parameter int SEL_W = 2
) (
    input  logic [NW*16-1:0]    a,
    input  logic [NW*16-1:0]    b,
    input  logic [NW*SEL_W-1:0] imm,
    output logic [NW*16-1:0]    smax,
    output logic [NW*16-1:0]    smin,
    output logic [NW*16-1:0]    mulhi,
    output logic [NW*16-1:0]    shuf
);

    logic [15:0] a_word [NW];

    for (genvar k = 0; k < NW; k++) begin : g_lane
        logic [15:0] x;
        logic [15:0] y;
        logic        a_gt;
        logic [31:0] prod;
        assign x         = a[16*k +: 16];
        assign y         = b[16*k +: 16];
        assign a_word[k] = x;
        assign a_gt      = $signed(x) > $signed(y);
        assign smax[16*k +: 16]  = a_gt ? x : y;
        assign smin[16*k +: 16]  = a_gt ? y : x;
        assign prod              = {16'b0, x} * {16'b0, y};
        assign mulhi[16*k +: 16] = prod[31:16];
    end

    for (genvar k = 0; k < NW; k++) begin : g_shuf
        logic [SEL_W-1:0] sel;
        assign sel              = imm[SEL_W*k +: SEL_W];
        assign shuf[16*k +: 16] = a_word[sel];
    end

endmodule

// File: rtl/simd_media_unit.sv
module simd_media_unit
    import simd_media_pkg::*;
#(
    parameter int DATA_W = SMU_DATA_W
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    input  logic [2:0]                           op,
    input  logic [DATA_W-1:0]                    src_a,
    input  logic [DATA_W-1:0]                    src_b,
    input  logic [(DATA_W/16)*$clog2(DATA_W/16)-1:0] imm,
    output logic                                 out_valid,
    output logic [DATA_W-1:0]                    result
);

    localparam int NB    = DATA_W / 8;
    localparam int NW    = DATA_W / 16;
    localparam int SEL_W = $clog2(NW);
    localparam int SUM_W = $clog2(NB * 255 + 1);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } smu_state_t;

    smu_state_t st_d, st_q;

    logic [DATA_W-1:0] b_max, b_min, w_max, w_min, w_mul, w_shuf;
    logic [SUM_W-1:0]  sad_sum;
    logic [NB-1:0]     msb_mask;

    smu_byte_unit #(.NB(NB), .SUM_W(SUM_W)) u_byte (
        .a    (src_a),
        .b    (src_b),
        .umax (b_max),
        .umin (b_min),
        .sad  (sad_sum),
        .msb  (msb_mask)
    );

    smu_word_unit #(.NW(NW), .SEL_W(SEL_W)) u_word (
        .a     (src_a),
        .b     (src_b),
        .imm   (imm),
        .smax  (w_max),
        .smin  (w_min),
        .mulhi (w_mul),
        .shuf  (w_shuf)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = '0;
            case (smu_op_e'(op))
                OP_UMAX8:   st_d.data = b_max;
                OP_UMIN8:   st_d.data = b_min;
                OP_SMAX16:  st_d.data = w_max;
                OP_SMIN16:  st_d.data = w_min;
                OP_MULHI16: st_d.data = w_mul;
                OP_SAD8:    st_d.data[SUM_W-1:0] = sad_sum;
                OP_MSBMASK: st_d.data[NB-1:0]    = msb_mask;
                OP_WSHUF:   st_d.data = w_shuf;
                default:    st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && result == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> (!out_valid && $stable(result)));

    // R7
    sad_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd5) |=> (result[DATA_W-1:16] == '0));

    // R8
    mask_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd6) |=> (result[DATA_W-1:NB] == '0));

endmodule

// File: tb/tb_simd_media_unit.sv
`timescale 1ns/1ps
module tb_simd_media_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [7:0]  imm = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    logic [63:0] lcg = 64'h0123_4567_89AB_CDEF;
    bit   done = 0;

    always #2 clk = ~clk;

    simd_media_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .imm(imm),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] rnd();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return {lcg[63:32], lcg[47:16]};
    endfunction

    function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a,
                                          input logic [63:0] b, input logic [7:0] im);
        logic [63:0] r = '0;
        int sum = 0;
        case (o)
            3'd0: for (int i = 0; i < 8; i++)
                      r[8*i +: 8] = (a[8*i +: 8] >= b[8*i +: 8]) ? a[8*i +: 8] : b[8*i +: 8];
            3'd1: for (int i = 0; i < 8; i++)
                      r[8*i +: 8] = (a[8*i +: 8] <= b[8*i +: 8]) ? a[8*i +: 8] : b[8*i +: 8];
            3'd2, 3'd3: for (int k = 0; k < 4; k++) begin
                      int sa = $signed(a[16*k +: 16]);
                      int sb = $signed(b[16*k +: 16]);
                      int v  = (o == 3'd2) ? ((sa > sb) ? sa : sb) : ((sa < sb) ? sa : sb);
                      r[16*k +: 16] = v[15:0];
                  end
            3'd4: for (int k = 0; k < 4; k++) begin
                      longint p = longint'(a[16*k +: 16]) * longint'(b[16*k +: 16]);
                      r[16*k +: 16] = 16'(p / 65536);
                  end
            3'd5: begin
                      for (int i = 0; i < 8; i++) begin
                          int x = a[8*i +: 8];
                          int y = b[8*i +: 8];
                          sum += (x > y) ? x - y : y - x;
                      end
                      r[15:0] = sum[15:0];
                  end
            3'd6: for (int i = 0; i < 8; i++) r[i] = a[8*i + 7];
            default: for (int k = 0; k < 4; k++) begin
                      int s = im[2*k +: 2];
                      r[16*k +: 16] = a[16*s +: 16];
                  end
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
                     req, act[64], act[63:0], exp[64], exp[63:0]);
        end
    endtask

    task automatic run_vec(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                           input logic [7:0] im, input string req);
        @(negedge clk);
        op = o; src_a = a; src_b = b; imm = im; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {out_valid, result}, {1'b1, model(o, a, b, im)});
    endtask

    // R2: idle cycle with new inputs must leave the result unchanged
    task automatic idle_check();
        logic [63:0] keep;
        keep = result;
        src_a = rnd(); src_b = rnd(); op = op + 3'd1; imm = imm + 8'd3;
        @(negedge clk);
        check("R2 hold", {out_valid, result}, {1'b0, keep});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] corner [8] = '{16'h0000, 16'h0001, 16'h7FFE, 16'h7FFF,
                                    16'h8000, 16'h8001, 16'hFFFE, 16'hFFFF};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset", {out_valid, result}, 65'd0);

        // R3 / R4: every unsigned byte pair, eight per vector
        for (int op_i = 0; op_i < 2; op_i++) begin
            for (int v = 0; v < 8192; v++) begin
                logic [63:0] a, b;
                for (int l = 0; l < 8; l++) begin
                    logic [15:0] p = 16'(v * 8 + l);
                    a[8*l +: 8] = p[15:8];
                    b[8*l +: 8] = p[7:0];
                end
                run_vec(3'(op_i), a, b, 8'h00, op_i == 0 ? "R3 byte max" : "R4 byte min");
            end
        end
        idle_check();

        // R5 / R6: signed word corner grid then random
        for (int o = 2; o <= 4; o++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j += 4) begin
                    logic [63:0] a = {corner[i], corner[(i+3)%8], corner[(i+5)%8], corner[i]};
                    logic [63:0] b = {corner[j], corner[j+1], corner[j+2], corner[j+3]};
                    run_vec(3'(o), a, b, 8'h00, o == 4 ? "R6 mul high" : "R5 word max/min");
                    run_vec(3'(o), b, a, 8'h00, o == 4 ? "R6 mul high" : "R5 word max/min");
                end
            end
            for (int n = 0; n < 1500; n++)
                run_vec(3'(o), rnd(), rnd(), 8'h00, o == 4 ? "R6 mul high" : "R5 word max/min");
            idle_check();
        end

        // R7: sum of absolute differences
        run_vec(3'd5, {8{8'hFF}}, 64'd0, 8'h00, "R7 sad max 2040");
        run_vec(3'd5, 64'd0, {8{8'hFF}}, 8'h00, "R7 sad max 2040");
        for (int x = 0; x < 256; x++) begin
            logic [63:0] a = {8{8'(x)}};
            run_vec(3'd5, a, a, 8'h00, "R7 sad equal");
            run_vec(3'd5, a, ~a, 8'h00, "R7 sad complement");
        end
        for (int n = 0; n < 1500; n++) run_vec(3'd5, rnd(), rnd(), 8'h00, "R7 sad random");

        // R8: all top-bit patterns
        for (int m = 0; m < 256; m++) begin
            logic [63:0] a = rnd() & {8{8'h7F}};
            for (int i = 0; i < 8; i++) a[8*i + 7] = m[i];
            run_vec(3'd6, a, rnd(), 8'(m), "R8 msb mask");
        end
        idle_check();

        // R9: all immediates
        for (int s = 0; s < 256; s++) run_vec(3'd7, rnd(), rnd(), 8'(s), "R9 word shuffle");
        idle_check();

        // R1: reset in mid-run
        run_vec(3'd0, {8{8'hA5}}, 64'd0, 8'h00, "R3 byte max");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R1 mid reset", {out_valid, result}, 65'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule